// File: doc/BRIEF.md
# PCI Target Bus Interface

This block is a 32-bit target agent on a synchronous PCI bus, clocked by the bus clock. It watches for address phases, decodes the bus command and address, and claims the cycle by driving device select. Two programmable base registers in configuration space place an I/O window and a memory window. Both windows map onto one internal register bank of `BANK_WORDS` 32-bit words.

Data phases are paced by the initiator-ready / target-ready handshake. A back-end ready input lets the bank insert wait states. Bursts advance the word address after every completed phase. A burst that reaches the last bank word is ended by the target with a disconnect-with-data. Every active-low bus signal that the target drives comes out as a value port plus an output-enable port; the pad tri-state is built outside the block.

Top module: `pci_tgt`

## Requirements
- R1: While `rst` is high, `ad_oe`, `trdy_oe`, `devsel_oe` and `stop_oe` are low at once, without waiting for a clock edge. After reset the target is idle and claims nothing until the next address phase.
- R2: The address phase is the clock on which `frame_n` is first sampled low. For a hit, `devsel_n_out` is low with `devsel_oe` high from the clock after the address phase, and not before. A miss is never claimed.
- R3: Commands are decoded from `cbe_n` in the address phase. 0010/0011 (I/O read/write) hit when the address lies in the base-0 window. 0110/0111 (memory read/write) hit in the base-1 window. 1010/1011 (configuration read/write) hit only when `idsel` is high. Every other code, including 0100, 0101, 1000 and 1001, is ignored.
- R4: A configuration write to byte offset 10h loads base 0, and one to offset 14h loads base 1. Only bits [31:log2(4*BANK_WORDS)] are writable. Reads return base 0 with bit 0 set (I/O indicator), base 1 as stored, and 0 for any other offset. Writing 200h to offset 10h places the I/O window at 200h.
- R5: A base register holding zero never produces a hit.
- R6: A data phase completes only on an edge where `irdy_n` and `trdy_n_out` are both low. For bank (I/O or memory) accesses, `trdy_n_out` stays high while `be_ready` is low. Configuration accesses do not wait on `be_ready`.
- R7: Once `trdy_n_out` is low and `irdy_n` is high, `trdy_n_out` stays low and `ad_out` holds its value on the next clock.
- R8: For a read, `ad_oe` turns on the clock after the address phase. `trdy_n_out` is still high in that turnaround clock. `ad_oe` is high only while the target has the cycle claimed.
- R9: On a write, byte lane k (AD[8k+7:8k]) is updated only when `cbe_n[k]` is low in that data phase.
- R10: In a burst, each completed data phase moves the access to the next 32-bit word, with no new address phase.
- R11: When a phase completes with `frame_n` high, the next clock has `devsel_oe`, `trdy_oe`, `stop_oe` and `ad_oe` all low, and the target is idle.
- R12: A data phase that targets the last bank word drives `stop_n_out` low together with `trdy_n_out`. After that phase completes, device select and stop are released on the same clock, even if `frame_n` is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Active-high reset |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Per-slot configuration select |
| cbe_n | input | 4 | Command in address phase, byte enables (active low) in data phases |
| ad_in | input | 32 | Address/data bus as seen at the pads |
| be_ready | input | 1 | Back-end ready; low inserts wait states on bank accesses |
| ad_out | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Output enable for AD |
| trdy_n_out | output | 1 | Target ready value, active low |
| trdy_oe | output | 1 | Output enable for target ready |
| devsel_n_out | output | 1 | Device select value, active low |
| devsel_oe | output | 1 | Output enable for device select |
| stop_n_out | output | 1 | Stop value, active low |
| stop_oe | output | 1 | Output enable for stop |

## Verification
The assertions assume a well-behaved initiator. It raises `frame_n` only while `irdy_n` is low or after the final phase. It does not start a new address phase while the target still holds the previous cycle. It keeps `frame_n` high for at least one clock between transactions. The bench's master tasks drive all bus inputs on the falling edge and follow these rules. After a disconnect they drop `frame_n` and `irdy_n` together. For unclaimed cycles they end with a short master-abort pattern of `irdy_n` low and `frame_n` high.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [3:0] {
    CMD_IO_RD  = 4'b0010,
    CMD_IO_WR  = 4'b0011,
    CMD_MEM_RD = 4'b0110,
    CMD_MEM_WR = 4'b0111,
    CMD_CFG_RD = 4'b1010,
    CMD_CFG_WR = 4'b1011
  } bus_cmd_e;

  typedef enum logic {
    ST_IDLE,
    ST_DATA
  } tgt_state_e;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int ADDR_LSB = 6
) (
  input  logic [3:0]           cmd,
  input  logic [31-ADDR_LSB:0] addr_hi,
  input  logic                 sel,
  input  logic [31-ADDR_LSB:0] io_hi,
  input  logic [31-ADDR_LSB:0] mem_hi,
  output logic                 hit,
  output logic                 is_read,
  output logic                 is_cfg
);
  logic io_match, mem_match;

  // an unprogrammed (zero) base never decodes
  assign io_match  = (io_hi  != '0) && (addr_hi == io_hi);
  assign mem_match = (mem_hi != '0) && (addr_hi == mem_hi);
  assign is_read   = ~cmd[0];

  always_comb begin
    hit    = 1'b0;
    is_cfg = 1'b0;
    case (cmd)
      CMD_IO_RD, CMD_IO_WR:   hit = io_match;
      CMD_MEM_RD, CMD_MEM_WR: hit = mem_match;
      CMD_CFG_RD, CMD_CFG_WR: begin
        hit    = sel;
        is_cfg = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pci_tgt_cfg.sv
module pci_tgt_cfg #(
  parameter int ADDR_LSB = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [5:0]           off,
  input  logic [31:0]          wdata,
  input  logic [3:0]           be,
  output logic [31-ADDR_LSB:0] io_hi,
  output logic [31-ADDR_LSB:0] mem_hi,
  output logic [31:0]          rdata
);
  localparam logic [5:0]  OFF_IO  = 6'h04;
  localparam logic [5:0]  OFF_MEM = 6'h05;
  localparam logic [31:0] WMASK   = ~((32'd1 << ADDR_LSB) - 32'd1);

  logic [31:0] base_io_q, base_mem_q;
  logic [31:0] lane_mask;

  always_comb begin
    for (int b = 0; b < 4; b++) lane_mask[8*b +: 8] = {8{be[b]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_io_q  <= '0;
      base_mem_q <= '0;
    end else if (we) begin
      if (off == OFF_IO)
        base_io_q  <= ((base_io_q & ~lane_mask) | (wdata & lane_mask)) & WMASK;
      if (off == OFF_MEM)
        base_mem_q <= ((base_mem_q & ~lane_mask) | (wdata & lane_mask)) & WMASK;
    end
  end

  always_comb begin
    case (off)
      OFF_IO:  rdata = base_io_q | 32'd1;
      OFF_MEM: rdata = base_mem_q;
      default: rdata = '0;
    endcase
  end

  assign io_hi  = base_io_q[31:ADDR_LSB];
  assign mem_hi = base_mem_q[31:ADDR_LSB];
endmodule

// File: rtl/pci_tgt_bank.sv
module pci_tgt_bank #(
  parameter int WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [3:0]       wbe,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  // one byte-wide array per lane, synchronous read: maps onto block RAM
  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && wbe[b]) mem[widx] <= wdata[8*b +: 8];
      rdata[8*b +: 8] <= mem[ridx];
    end
  end
endmodule

// File: rtl/pci_tgt.sv
module pci_tgt
  import pci_tgt_pkg::*;
#(
  parameter int BANK_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  input  logic        be_ready,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        trdy_n_out,
  output logic        trdy_oe,
  output logic        devsel_n_out,
  output logic        devsel_oe,
  output logic        stop_n_out,
  output logic        stop_oe
);
  localparam int IDX_W    = $clog2(BANK_WORDS);
  localparam int ADDR_LSB = IDX_W + 2;
  localparam int OW       = (IDX_W > 6) ? IDX_W : 6;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_WORDS - 1);

  tgt_state_e state;
  logic          frame_q;
  logic [OW-1:0] addr_q;
  logic          cfg_q, rd_q;
  logic          trdy_n_q, devsel_n_q, stop_n_q;
  logic          ad_oe_q, trdy_oe_q, devsel_oe_q, stop_oe_q;

  logic              hit, dec_read, dec_cfg;
  logic [31-ADDR_LSB:0] io_hi, mem_hi;
  logic [31:0]       cfg_rdata, bank_rdata;
  logic              addr_phase, complete, finish, wait_be;
  logic              trdy_n_d, stop_n_d;
  logic [OW-1:0]     nxt_off;
  logic [IDX_W-1:0]  nxt_idx, ridx;
  logic              cfg_we, bank_we;

  pci_tgt_decode #(.ADDR_LSB(ADDR_LSB)) u_decode (
    .cmd    (cbe_n),
    .addr_hi(ad_in[31:ADDR_LSB]),
    .sel    (idsel),
    .io_hi  (io_hi),
    .mem_hi (mem_hi),
    .hit    (hit),
    .is_read(dec_read),
    .is_cfg (dec_cfg)
  );

  assign addr_phase = (state == ST_IDLE) && !frame_n && frame_q;
  assign complete   = (state == ST_DATA) && !irdy_n && !trdy_n_q;
  assign finish     = complete && (frame_n || !stop_n_q);
  assign wait_be    = !cfg_q && !be_ready;
  assign nxt_off    = addr_q + OW'(complete);
  assign nxt_idx    = nxt_off[IDX_W-1:0];
  assign ridx       = (state == ST_IDLE) ? ad_in[IDX_W+1:2] : nxt_idx;
  assign cfg_we     = complete && cfg_q && !rd_q;
  assign bank_we    = complete && !cfg_q && !rd_q;

  // hold target-ready through an initiator wait, else re-evaluate back-end
  assign trdy_n_d = (!trdy_n_q && !complete) ? 1'b0 : wait_be;
  assign stop_n_d = trdy_n_d || cfg_q || (nxt_idx != LAST_IDX);

  pci_tgt_cfg #(.ADDR_LSB(ADDR_LSB)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .off   (addr_q[5:0]),
    .wdata (ad_in),
    .be    (~cbe_n),
    .io_hi (io_hi),
    .mem_hi(mem_hi),
    .rdata (cfg_rdata)
  );

  pci_tgt_bank #(.WORDS(BANK_WORDS), .IDX_W(IDX_W)) u_bank (
    .clk  (clk),
    .we   (bank_we),
    .widx (addr_q[IDX_W-1:0]),
    .wdata(ad_in),
    .wbe  (~cbe_n),
    .ridx (ridx),
    .rdata(bank_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      frame_q     <= 1'b1;
      addr_q      <= '0;
      cfg_q       <= 1'b0;
      rd_q        <= 1'b0;
      trdy_n_q    <= 1'b1;
      devsel_n_q  <= 1'b1;
      stop_n_q    <= 1'b1;
      ad_oe_q     <= 1'b0;
      trdy_oe_q   <= 1'b0;
      devsel_oe_q <= 1'b0;
      stop_oe_q   <= 1'b0;
    end else begin
      frame_q <= frame_n;
      case (state)
        ST_IDLE: begin
          if (addr_phase && hit) begin
            state       <= ST_DATA;
            addr_q      <= ad_in[OW+1:2];
            cfg_q       <= dec_cfg;
            rd_q        <= dec_read;
            devsel_n_q  <= 1'b0;
            devsel_oe_q <= 1'b1;
            trdy_oe_q   <= 1'b1;
            stop_oe_q   <= 1'b1;
            trdy_n_q    <= 1'b1;
            stop_n_q    <= 1'b1;
            ad_oe_q     <= dec_read;
          end
        end
        ST_DATA: begin
          if (finish) begin
            state       <= ST_IDLE;
            devsel_n_q  <= 1'b1;
            trdy_n_q    <= 1'b1;
            stop_n_q    <= 1'b1;
            ad_oe_q     <= 1'b0;
            trdy_oe_q   <= 1'b0;
            devsel_oe_q <= 1'b0;
            stop_oe_q   <= 1'b0;
          end else begin
            addr_q   <= nxt_off;
            trdy_n_q <= trdy_n_d;
            stop_n_q <= stop_n_d;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ad_out       = cfg_q ? cfg_rdata : bank_rdata;
  assign trdy_n_out   = trdy_n_q;
  assign devsel_n_out = devsel_n_q;
  assign stop_n_out   = stop_n_q;
  // enables drop with reset immediately, not on the next edge
  assign ad_oe        = ad_oe_q     & ~rst;
  assign trdy_oe      = trdy_oe_q   & ~rst;
  assign devsel_oe    = devsel_oe_q & ~rst;
  assign stop_oe      = stop_oe_q   & ~rst;
endmodule

// File: rtl/pci_tgt_chk.sv
module pci_tgt_chk (
  input logic        clk,
  input logic        rst,
  input logic        frame_n,
  input logic        irdy_n,
  input logic [31:0] ad_out,
  input logic        ad_oe,
  input logic        trdy_n_out,
  input logic        trdy_oe,
  input logic        devsel_n_out,
  input logic        devsel_oe,
  input logic        stop_n_out,
  input logic        stop_oe
);
  always_comb begin
    if (rst) begin
      a_r1_outputs_off: assert (!ad_oe && !trdy_oe && !devsel_oe && !stop_oe);
    end
  end

  a_r2_claim_after_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(devsel_oe) |-> $past(!frame_n));

  a_r6_trdy_needs_devsel: assert property (@(posedge clk) disable iff (rst)
    (trdy_oe && !trdy_n_out) |-> (devsel_oe && !devsel_n_out));

  a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (trdy_oe && !trdy_n_out && irdy_n) |=> (!trdy_n_out && $stable(ad_out)));

  a_r8_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> trdy_n_out);

  a_r8_ad_only_claimed: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> devsel_oe);

  a_r11_release_together: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_oe) |-> (!stop_oe && !trdy_oe && !ad_oe));

  a_r12_stop_with_trdy: assert property (@(posedge clk) disable iff (rst)
    (stop_oe && !stop_n_out) |-> (!trdy_n_out && devsel_oe));
endmodule

bind pci_tgt pci_tgt_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_n     (frame_n),
  .irdy_n      (irdy_n),
  .ad_out      (ad_out),
  .ad_oe       (ad_oe),
  .trdy_n_out  (trdy_n_out),
  .trdy_oe     (trdy_oe),
  .devsel_n_out(devsel_n_out),
  .devsel_oe   (devsel_oe),
  .stop_n_out  (stop_n_out),
  .stop_oe     (stop_oe)
);

// File: tb/pci_tgt_bench.sv
module pci_tgt_bench;
  localparam int BW = 16;
  localparam logic [31:0] BASE_IO  = 32'h0000_0200;
  localparam logic [31:0] BASE_MEM = 32'h8000_0000;
  localparam logic [3:0] C_IO_RD = 4'b0010, C_IO_WR = 4'b0011;
  localparam logic [3:0] C_MEM_RD = 4'b0110, C_MEM_WR = 4'b0111;
  localparam logic [3:0] C_CFG_RD = 4'b1010, C_CFG_WR = 4'b1011;

  logic clk = 1'b0, rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, be_ready = 1'b1;
  logic [3:0] cbe_n = 4'h0;
  logic [31:0] ad_in = 32'h0;
  logic [31:0] ad_out;
  logic ad_oe, trdy_n_out, trdy_oe, devsel_n_out, devsel_oe, stop_n_out, stop_oe;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] wbuf [16];
  logic [31:0] rbuf [16];
  bit sbuf [16];
  logic [31:0] model [BW];
  bit g_dev, g_adoe, g_trdy, g_rel;

  pci_tgt u_pci_tgt (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .be_ready(be_ready), .ad_out(ad_out),
    .ad_oe(ad_oe), .trdy_n_out(trdy_n_out), .trdy_oe(trdy_oe),
    .devsel_n_out(devsel_n_out), .devsel_oe(devsel_oe),
    .stop_n_out(stop_n_out), .stop_oe(stop_oe)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  // one bus transaction; data phases driven on falling edges
  task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                      input int n, input logic [3:0] be, input bit rd,
                      output int done, output bit stopped);
    int guard;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad_in = addr; idsel = sel;
    @(negedge clk);
    g_dev  = devsel_oe && !devsel_n_out;
    g_adoe = ad_oe;
    g_trdy = trdy_oe && !trdy_n_out;
    idsel = 1'b0; irdy_n = 1'b0; cbe_n = be; frame_n = (n == 1);
    ad_in = rd ? 32'h0 : wbuf[0];
    done = 0; stopped = 0; guard = 0;
    while (done < n && !stopped && guard < 60) begin
      guard++;
      if (trdy_oe && !trdy_n_out) begin
        rbuf[done] = ad_out;
        stopped = stop_oe && !stop_n_out;
        sbuf[done] = stopped;
        done++;
        @(negedge clk);
        if (done < n && !stopped) begin
          frame_n = (done == n - 1);
          if (!rd) ad_in = wbuf[done];
        end
      end else begin
        @(negedge clk);
      end
    end
    g_rel = !devsel_oe && !trdy_oe && !stop_oe && !ad_oe;
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'h0; ad_in = 32'h0;
    if (guard >= 60) chk(1'b0, "R6", "transaction timed out", done, n);
  endtask

  task automatic no_claim(input logic [3:0] cmd, input logic [31:0] addr,
                          input bit sel, input string req, input string what);
    bit seen = 0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad_in = addr; idsel = sel;
    @(negedge clk);
    idsel = 1'b0; frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0; ad_in = 32'h0;
    for (int i = 0; i < 5; i++) begin
      if (devsel_oe || trdy_oe) seen = 1;
      @(negedge clk);
    end
    irdy_n = 1'b1;
    chk(!seen, req, what, seen, 0);
  endtask

  task automatic t_reset;
    repeat (3) begin
      @(negedge clk);
      chk(!ad_oe && !trdy_oe && !devsel_oe && !stop_oe, "R1", "enables during reset",
          {ad_oe, trdy_oe, devsel_oe, stop_oe}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(!devsel_oe, "R1", "idle after reset", devsel_oe, 0);
  endtask

  task automatic t_zero_base;
    no_claim(C_IO_WR, 32'h0, 0, "R5", "io write with zero base claimed");
    no_claim(C_MEM_RD, 32'h0, 0, "R5", "mem read with zero base claimed");
  endtask

  task automatic t_config;
    int d; bit s;
    wbuf[0] = 32'h0000_0200;
    xfer(C_CFG_WR, 32'h10, 1, 1, 4'b0000, 0, d, s);
    chk(g_dev, "R2", "devsel one clock after address phase", g_dev, 1);
    chk(!g_adoe, "R8", "no AD drive on a write", g_adoe, 0);
    wbuf[0] = 32'h8000_003F;
    xfer(C_CFG_WR, 32'h14, 1, 1, 4'b0000, 0, d, s);
    xfer(C_CFG_RD, 32'h10, 1, 1, 4'b0000, 1, d, s);
    chk(g_adoe && !g_trdy, "R8", "turnaround: oe on, trdy high", {g_adoe, g_trdy}, 2'b10);
    chk_eq("R4", "base0 readback", rbuf[0], 32'h0000_0201);
    xfer(C_CFG_RD, 32'h14, 1, 1, 4'b0000, 1, d, s);
    chk_eq("R4", "base1 readback masked", rbuf[0], 32'h8000_0000);
    xfer(C_CFG_RD, 32'h18, 1, 1, 4'b0000, 1, d, s);
    chk_eq("R4", "other offset reads zero", rbuf[0], 32'h0);
  endtask

  task automatic t_decode;
    int d; bit s;
    no_claim(C_CFG_WR, 32'h10, 0, "R3", "config without idsel claimed");
    xfer(C_CFG_RD, 32'h10, 1, 1, 4'b0000, 1, d, s);
    chk_eq("R3", "base0 unchanged after unselected write", rbuf[0], 32'h0000_0201);
    no_claim(4'b0100, BASE_IO, 0, "R3", "reserved 0100 claimed");
    no_claim(4'b1000, BASE_MEM, 0, "R3", "reserved 1000 claimed");
    no_claim(C_IO_RD, BASE_IO + 32'h40, 0, "R2", "io read outside window claimed");
  endtask

  task automatic t_io_rw;
    int d; bit s;
    wbuf[0] = 32'hA5A5_1234; model[1] = 32'hA5A5_1234;
    xfer(C_IO_WR, BASE_IO + 32'h4, 0, 1, 4'b0000, 0, d, s);
    chk(g_rel, "R11", "release after single write", g_rel, 1);
    xfer(C_IO_RD, BASE_IO + 32'h4, 0, 1, 4'b0000, 1, d, s);
    chk_eq("R3", "io read back", rbuf[0], model[1]);
    xfer(C_MEM_RD, BASE_MEM + 32'h4, 0, 1, 4'b0000, 1, d, s);
    chk_eq("R3", "memory window sees same word", rbuf[0], model[1]);
  endtask

  task automatic t_burst;
    int d; bit s; bit ok = 1;
    for (int i = 0; i < 4; i++) begin
      wbuf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
      model[4 + i] = wbuf[i];
    end
    xfer(C_MEM_WR, BASE_MEM + 32'h10, 0, 4, 4'b0000, 0, d, s);
    chk(d == 4 && !s, "R10", "write burst length", d, 4);
    xfer(C_MEM_RD, BASE_MEM + 32'h10, 0, 4, 4'b0000, 1, d, s);
    chk(d == 4 && !s, "R10", "read burst length", d, 4);
    for (int i = 0; i < 4; i++) if (rbuf[i] !== model[4 + i]) ok = 0;
    chk(ok, "R10", "burst words in order", rbuf[3], model[7]);
  endtask

  task automatic t_bytes;
    int d; bit s;
    wbuf[0] = 32'h1122_3344;
    xfer(C_MEM_WR, BASE_MEM + 32'h8, 0, 1, 4'b0000, 0, d, s);
    wbuf[0] = 32'hAABB_CCDD;
    xfer(C_MEM_WR, BASE_MEM + 32'h8, 0, 1, 4'b1010, 0, d, s);
    xfer(C_MEM_RD, BASE_MEM + 32'h8, 0, 1, 4'b0000, 1, d, s);
    chk_eq("R9", "lanes 0 and 2 only", rbuf[0], 32'h11BB_33DD);
  endtask

  task automatic t_waits;
    bit ok = 1;
    logic [31:0] held;
    be_ready = 1'b0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = C_MEM_RD; ad_in = BASE_MEM + 32'h10;
    @(negedge clk);
    cbe_n = 4'h0; ad_in = 32'h0;
    repeat (3) begin
      @(negedge clk);
      if (trdy_n_out !== 1'b1 || devsel_n_out !== 1'b0) ok = 0;
    end
    chk(ok, "R6", "trdy high while back-end not ready", trdy_n_out, 1);
    be_ready = 1'b1;
    @(negedge clk);
    held = ad_out;
    chk(!trdy_n_out, "R6", "trdy after back-end ready", trdy_n_out, 0);
    chk_eq("R6", "read data", held, model[4]);
    @(negedge clk);
    chk(!trdy_n_out && ad_out === held, "R7", "hold through initiator wait", ad_out, held);
    irdy_n = 1'b0; frame_n = 1'b1;
    @(negedge clk);
    chk(!devsel_oe && !trdy_oe && !stop_oe && !ad_oe, "R11", "release after last phase",
        {ad_oe, trdy_oe, devsel_oe, stop_oe}, 0);
    irdy_n = 1'b1;
  endtask

  task automatic t_cfg_nowait;
    int d; bit s;
    be_ready = 1'b0;
    xfer(C_CFG_RD, 32'h14, 1, 1, 4'b0000, 1, d, s);
    chk(d == 1 && rbuf[0] === 32'h8000_0000, "R6", "config ignores back-end ready", rbuf[0], 32'h8000_0000);
    be_ready = 1'b1;
  endtask

  task automatic t_stop;
    int d; bit s;
    wbuf[0] = 32'hEEEE_0014; wbuf[1] = 32'hFFFF_0015;
    xfer(C_MEM_WR, BASE_MEM + 32'h38, 0, 2, 4'b0000, 0, d, s);
    xfer(C_MEM_RD, BASE_MEM + 32'h38, 0, 4, 4'b0000, 1, d, s);
    chk(d == 2 && s, "R12", "disconnect after last word", d, 2);
    chk(!sbuf[0], "R12", "no stop before last word", sbuf[0], 0);
    chk_eq("R12", "last word data", rbuf[1], 32'hFFFF_0015);
    chk(g_rel, "R12", "devsel and stop released together", g_rel, 1);
  endtask

  task automatic t_async_off;
    be_ready = 1'b0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = C_IO_RD; ad_in = BASE_IO;
    @(negedge clk);
    cbe_n = 4'h0;
    chk(devsel_oe && ad_oe, "R1", "claimed before reset", devsel_oe, 1);
    #2 rst = 1'b1;
    #1;
    chk(!ad_oe && !trdy_oe && !devsel_oe && !stop_oe, "R1", "enables drop without clock",
        {ad_oe, trdy_oe, devsel_oe, stop_oe}, 0);
    frame_n = 1'b1; be_ready = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!devsel_oe, "R1", "idle after second reset", devsel_oe, 0);
  endtask

  initial begin
    t_reset();
    t_zero_base();
    t_config();
    t_decode();
    t_io_rw();
    t_burst();
    t_bytes();
    t_waits();
    t_cfg_nowait();
    t_stop();
    t_async_off();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run hung actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule